// File: doc/BRIEF.md
# Self-Selecting Multiplexed Processor Bus Port

This block is the register-access port of a larger device. It connects to a processor bus on which address and data share one set of lines. It works out by itself which of two bus styles drives it. In the first style the pins are an address strobe, a data strobe and a read/write level. In the second style the pins are an address-latch-enable and separate active-low read and write strobes. On every rising edge of the shared address pin, the port samples the shared data-strobe/read pin. It then reads the strobe and direction pins in the way that the sampled style requires.

The port takes the register address from the low bits of the shared bus. It decodes reads and writes to a file of eight byte-wide registers and drives read data back out with an output enable for a tri-state pad. Bit 0 of the master control register at address 0 is brought out as a plain level. Another block uses it to choose whether control-channel writes come from this port or from the serial stream.

The port is a slave on a processor bus, and that bus sets the transfer rules. For this reason it has no valid/ready handshake and cannot apply back-pressure. Every input is registered once on the system clock before use. The bus timing must therefore hold each phase for at least two clock periods.

Top module: `mbus_port`

## Requirements
- R1: A rising edge on as_ale while ctrl_mode is high stores the bus style. If ds_rd is 0 at that edge, the strobe-plus-direction style is selected. If ds_rd is 1, the split-strobe style is selected. After reset the split-strobe style is in force until the first such edge.
- R2: A falling edge on as_ale while ctrl_mode is high loads the register address from ad_in[2:0]. The address does not change at any other time.
- R3: In the strobe-plus-direction style, an access needs cs_n = 0. It is a write while ds_rd = 1 and rw_wr = 0, and a read while ds_rd = 1 and rw_wr = 1.
- R4: In the split-strobe style, an access needs cs_n = 0. rw_wr = 0 marks a write and ds_rd = 0 marks a read.
- R5: A write takes effect when its strobe ends. The value stored is the ad_in value that was present during the strobe.
- R6: ad_oe is 1 only while a read is active. While ad_oe is 1, ad_out carries the addressed register.
- R7: While ctrl_mode is 0, the port ignores every bus cycle. No write happens, the style and address do not change, and ad_oe stays 0.
- R8: Reset clears every register, so cchan_src is 0.
- R9: Only some bits are implemented: register 0 has bits [3:0], register 7 has bits [5:0], and registers 1 to 6 have all eight bits. Writes to the other bits are dropped, and those bits read as 0.
- R10: cchan_src always equals bit 0 of register 0.
- R11: A read leaves every register unchanged.
- R12: While cs_n is 1, no read or write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_mode | input | 1 | Enables the port when high |
| cs_n | input | 1 | Active-low chip select |
| as_ale | input | 1 | Address strobe or address-latch-enable |
| ds_rd | input | 1 | Data strobe (high active) or read strobe (low active) |
| rw_wr | input | 1 | Read/write level or write strobe (low active) |
| ad_in | input | 8 | Shared address/data bus, input side |
| ad_out | output | 8 | Read data for the shared bus |
| ad_oe | output | 1 | Output enable for the bus pads |
| cchan_src | output | 1 | Bit 0 of the master control register |

## Verification
All pins pass through one register stage, so each result has a fixed delay from the pin change that causes it. ad_oe and ad_out follow a read strobe one rising edge after the pins change. A new style or address is used two edges after the as_ale transition. A written value appears, and so does cchan_src, two edges after the strobe is removed. The bench reference model applies exactly these delays. Its state is updated on each rising edge and compared with the outputs on each falling edge. Directed reads then check the stored values against constants taken from the requirements.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int DW = 8;
  localparam int NREG = 8;

  typedef enum logic {
    STYLE_STRB_RW = 1'b0,
    STYLE_SPLIT   = 1'b1
  } bus_style_e;
endpackage

// File: rtl/mbus_insync.sv
module mbus_insync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_pkg::*;
#(
  parameter int AW = 3,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl,
  input  logic          cs_n,
  input  logic          as_p,
  input  logic          ds_rd,
  input  logic          rw_wr,
  input  logic [W-1:0]  ad,
  output logic [AW-1:0] addr,
  output logic          rd_act,
  output logic          wr_commit,
  output logic [W-1:0]  wdata
);
  bus_style_e style_q;
  logic as_q, wr_q, wr_act, sel, as_rise, as_fall;

  assign as_rise = ctrl & as_p & ~as_q;
  assign as_fall = ctrl & ~as_p & as_q;
  assign sel     = ctrl & ~cs_n;

  always_comb begin
    if (style_q == STYLE_STRB_RW) begin
      rd_act = sel & ds_rd & rw_wr;
      wr_act = sel & ds_rd & ~rw_wr;
    end else begin
      rd_act = sel & ~ds_rd;
      wr_act = sel & ~rw_wr;
    end
  end

  assign wr_commit = wr_q & ~wr_act & ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style_q <= STYLE_SPLIT;
      as_q    <= 1'b0;
      addr    <= '0;
      wr_q    <= 1'b0;
      wdata   <= '0;
    end else begin
      as_q <= as_p;
      wr_q <= wr_act;
      if (as_rise) style_q <= ds_rd ? STYLE_SPLIT : STYLE_STRB_RW;
      if (as_fall) addr <= ad[AW-1:0];
      if (wr_act)  wdata <= ad;
    end
  end

  a_r1_style_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !as_rise |=> $stable(style_q));
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !as_fall |=> $stable(addr));
  a_r7_no_commit_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl |-> !wr_commit);
  a_r12_no_read_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !rd_act);
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile #(
  parameter int NREG = 8,
  parameter int W    = 8,
  parameter logic [NREG*W-1:0] IMPL_MASK = '1,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          bit0_out
);
  logic [W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [W-1:0] MASK = IMPL_MASK[i*W +: W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[i] <= '0;
      else if (we && (waddr == AW'(i))) regs[i] <= wdata & MASK;
    end
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(regs[i]));
  end

  assign rdata    = regs[raddr];
  assign bit0_out = regs[0][0];
endmodule

// File: rtl/mbus_port.sv
module mbus_port
  import mbus_pkg::*;
#(
  parameter int NR = NREG,
  parameter int W  = DW,
  parameter logic [NR*W-1:0] IMPL_MASK = {8'h3F, {6{8'hFF}}, 8'h0F},
  localparam int AW = $clog2(NR)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_mode,
  input  logic         cs_n,
  input  logic         as_ale,
  input  logic         ds_rd,
  input  logic         rw_wr,
  input  logic [W-1:0] ad_in,
  output logic [W-1:0] ad_out,
  output logic         ad_oe,
  output logic         cchan_src
);
  logic         ctrl_s, cs_s, as_s, ds_s, rw_s;
  logic [W-1:0] ad_s, wdata;
  logic [AW-1:0] addr;
  logic         rd_act, wr_commit;

  mbus_insync #(.W(5 + W)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ctrl_mode, cs_n, as_ale, ds_rd, rw_wr, ad_in}),
    .q({ctrl_s, cs_s, as_s, ds_s, rw_s, ad_s})
  );

  mbus_decode #(.AW(AW), .W(W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_s), .cs_n(cs_s), .as_p(as_s),
    .ds_rd(ds_s), .rw_wr(rw_s), .ad(ad_s), .addr(addr), .rd_act(rd_act),
    .wr_commit(wr_commit), .wdata(wdata)
  );

  mbus_regfile #(.NREG(NR), .W(W), .IMPL_MASK(IMPL_MASK)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_commit), .waddr(addr), .wdata(wdata),
    .raddr(addr), .rdata(ad_out), .bit0_out(cchan_src)
  );

  assign ad_oe = rd_act;

  a_r6_oe_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (ctrl_s && !cs_s));
  a_r10_cchan_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(cchan_src));
endmodule

// File: tb/sim_mbus_port.sv
module sim_mbus_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_mode = 1'b1, cs_n = 1'b1, as_ale = 1'b0, ds_rd = 1'b1, rw_wr = 1'b1;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ad_out;
  logic ad_oe, cchan_src;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  mbus_port u0 (.clk(clk), .rst_n(rst_n), .ctrl_mode(ctrl_mode), .cs_n(cs_n),
    .as_ale(as_ale), .ds_rd(ds_rd), .rw_wr(rw_wr), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .cchan_src(cchan_src));

  function automatic logic [7:0] mmask(int a);
    return (a == 0) ? 8'h0F : (a == 7) ? 8'h3F : 8'hFF;
  endfunction

  // behavioural reference model
  logic [7:0] mregs [8];
  int   maddr, pend_a;
  bit   mstyle, pend_style, pend_sv, pend_av, pend_we;
  int   pend_addr;
  logic [7:0] pend_d, p_ad;
  bit   p_wr, p_as;
  bit   exp_oe, exp_cc;
  logic [7:0] exp_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mregs[i]) mregs[i] = 8'h00;
      maddr = 0; mstyle = 1; pend_sv = 0; pend_av = 0; pend_we = 0;
      p_wr = 0; p_as = 0; p_ad = 8'h00; exp_oe = 0; exp_cc = 0; exp_out = 8'h00;
    end else begin
      bit sel, rd, wr;
      if (pend_we) mregs[pend_a] = pend_d & mmask(pend_a);
      if (pend_sv) mstyle = pend_style;
      if (pend_av) maddr = pend_addr;
      pend_we = 0; pend_sv = 0; pend_av = 0;
      sel = ctrl_mode && !cs_n;
      rd = sel && (mstyle == 0 ? (ds_rd && rw_wr) : !ds_rd);
      wr = sel && (mstyle == 0 ? (ds_rd && !rw_wr) : !rw_wr);
      exp_oe = rd; exp_out = mregs[maddr]; exp_cc = mregs[0][0];
      if (p_wr && !wr && ctrl_mode) begin pend_we = 1; pend_a = maddr; pend_d = p_ad; end
      if (ctrl_mode && as_ale && !p_as) begin pend_sv = 1; pend_style = ds_rd; end
      if (ctrl_mode && !as_ale && p_as) begin pend_av = 1; pend_addr = int'(ad_in[2:0]); end
      p_wr = wr; p_as = as_ale; p_ad = ad_in;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R6 oe", {7'b0, ad_oe}, {7'b0, exp_oe});
    if (exp_oe) check("R6 data", ad_out, exp_out);
    check("R10 cchan", {7'b0, cchan_src}, {7'b0, exp_cc});
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // address phase; style_a selects the strobe-plus-direction style
  task automatic addr_phase(bit style_a, logic [7:0] a);
    cs_n = 1; ad_in = a;
    ds_rd = style_a ? 1'b0 : 1'b1; rw_wr = 1;
    tick(1); as_ale = 1; tick(2); as_ale = 0; tick(2);
  endtask

  task automatic bwrite(bit style_a, logic [7:0] a, logic [7:0] d, bit csn = 0);
    addr_phase(style_a, a);
    cs_n = csn; ad_in = d;
    if (style_a) begin rw_wr = 0; tick(1); ds_rd = 1; tick(3); ds_rd = 0; tick(1); rw_wr = 1; end
    else begin rw_wr = 0; tick(3); rw_wr = 1; end
    tick(1); cs_n = 1; tick(2);
  endtask

  task automatic bread(bit style_a, logic [7:0] a, output logic [7:0] d, output logic oe);
    addr_phase(style_a, a);
    cs_n = 0;
    if (style_a) begin rw_wr = 1; tick(1); ds_rd = 1; end
    else ds_rd = 0;
    tick(2); @(negedge clk); d = ad_out; oe = ad_oe;
    tick(1);
    ds_rd = style_a ? 1'b0 : 1'b1; tick(1); cs_n = 1; tick(2);
  endtask

  initial begin
    logic [7:0] d; logic oe;
    tick(3); rst_n = 1; tick(1);
    @(negedge clk);
    check("R8 cchan after reset", {7'b0, cchan_src}, 8'h00);
    check("R8 oe after reset", {7'b0, ad_oe}, 8'h00);
    tick(1);
    bread(0, 8'h04, d, oe);          check("R8 reg4 cleared", d, 8'h00);
    bwrite(0, 8'h00, 8'hFF);         check("R10 cchan set", {7'b0, cchan_src}, 8'h01);
    bread(0, 8'h00, d, oe);          check("R9 reg0 mask", d, 8'h0F);
    bwrite(0, 8'h03, 8'hA5);
    bread(0, 8'h03, d, oe);          check("R4 R5 R2 reg3", d, 8'hA5);
    check("R6 oe during read", {7'b0, oe}, 8'h01);
    bwrite(1, 8'h05, 8'h3C);
    bread(1, 8'h05, d, oe);          check("R1 R3 style A reg5", d, 8'h3C);
    bread(1, 8'h03, d, oe);          check("R3 reg3 in style A", d, 8'hA5);
    bread(1, 8'h03, d, oe);          check("R11 reread reg3", d, 8'hA5);
    bwrite(1, 8'h05, 8'h00, 1);
    bread(1, 8'h05, d, oe);          check("R12 unselected write", d, 8'h3C);
    ctrl_mode = 0;
    bwrite(0, 8'h05, 8'h11);
    bread(1, 8'h05, d, oe);          check("R7 oe off", {7'b0, oe}, 8'h00);
    ctrl_mode = 1; tick(2);
    bread(1, 8'h05, d, oe);          check("R7 no write while off", d, 8'h3C);
    bwrite(1, 8'h07, 8'hFF);
    bread(1, 8'h07, d, oe);          check("R9 reg7 mask", d, 8'h3F);
    bwrite(1, 8'h00, 8'h02);         check("R10 cchan clear", {7'b0, cchan_src}, 8'h00);
    bread(0, 8'h00, d, oe);          check("R1 back to split reg0", d, 8'h02);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule